// File: doc/BRIEF.md
# Segmented Address Generator with Bit-20 Gate

This block turns a 16-bit segment and 16-bit offset into a physical address on a 24-bit memory bus. In real mode the segment is shifted left by four bits and the zero-extended offset is added to it, giving a 21-bit sum that can run just past the first megabyte. In protected mode a 24-bit linear address supplied by upstream translation is used instead of the sum.

Address bit 20 then goes through a gate. The gate clears that one bit, so a closed gate makes sums just above 1 MB fold back to the bottom of memory, as old real-mode code expects. A gate register, written by software, sets the gate open or closed, and the register resets to closed. A separate active-low pin can also force the bit to zero. Only bit 20 is cleared. Addresses therefore alias in alternating megabytes and are not reduced modulo 1 MB.

Requests arrive on a valid/ready stream, and results leave on a valid/ready stream through one output register. The upstream side sees `req_ready` high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is accepted. The gate write port and the mask pin are plain control signals.

Top module: `phys_addr_gen`

## Requirements
- R1: In real mode (`prot_mode`=0) the result is segment×16 + offset, formed as a 21-bit sum and zero-extended to 24 bits.
- R2: While the gate is closed, result bit 20 is 0. For example, F800:8000 gives 0x000000 and FFFF:00D0 gives 0x0000C0.
- R3: While the gate is open and `mask_n` is high, bit 20 passes through. For example, F800:8000 gives 0x100000 and FFFF:FFFF gives 0x10FFEF.
- R4: Masking clears bit 20 only. Bits 23:21 and 19:0 always equal those of the unmasked address, so with the gate closed the 1–2, 3–4 and 5–6 MB ranges drop by 1 MB while the 2–3 and 4–5 MB ranges are unchanged.
- R5: After reset the gate is closed (`gate_open`=0), `out_valid` is 0 and `req_ready` is 1.
- R6: While `mask_n` is 0 when a request is accepted, result bit 20 is 0 whatever the gate state.
- R7: In protected mode (`prot_mode`=1) the 24-bit `lin_addr` replaces the segment:offset sum, and the same bit-20 masking applies to it.
- R8: A cycle with `cfg_we`=1 loads `cfg_wdata` bit 1 into the gate (1 = open, 0 = closed). The other data bits are ignored. `gate_open` shows the stored value from the next cycle on.
- R9: A gate write in the same cycle as an accepted request applies to that request.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1, and its result appears with `out_valid`=1 one clock later. `req_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, `phys_addr` and `out_valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| seg | input | 16 | Real-mode segment |
| off | input | 16 | Real-mode offset |
| prot_mode | input | 1 | 1 = use lin_addr, 0 = segment:offset |
| lin_addr | input | 24 | Protected-mode linear address |
| mask_n | input | 1 | Active-low force of bit 20 to zero |
| cfg_we | input | 1 | Gate register write strobe |
| cfg_wdata | input | 8 | Gate write data, bit 1 = open |
| gate_open | output | 1 | Current gate register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts result |
| phys_addr | output | 24 | Gated physical address |

## Verification
Two cases are hard to reach from the ports. The first is a gate write landing in the same cycle as a request. The bench raises the write strobe and the request together and checks that the single result already reflects the new gate value, in both the opening and the closing direction. The second is back-pressure. The bench stalls `out_ready` with a result held, offers a different request during the stall, and then releases the stall in the same cycle so that draining and accepting overlap. Real-mode pairs, including the four boundary pairs, are swept under every gate and pin combination, and protected-mode addresses are stepped through each megabyte.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
  localparam int SEG_W     = 16;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W      = 24;
  localparam int GATE_BIT  = 20;
  localparam int CFG_W     = 8;
  localparam int CFG_OPEN  = 1;

  typedef enum logic {MODE_REAL = 1'b0, MODE_PROT = 1'b1} addr_mode_e;
endpackage

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int HI_W = SEG_W + SHIFT,
  localparam int SUM_W = ((HI_W > OFF_W) ? HI_W : OFF_W) + 1
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] seg_ext;
  logic [SUM_W-1:0] off_ext;

  always_comb begin
    seg_ext = SUM_W'({seg, {SHIFT{1'b0}}});
    off_ext = SUM_W'(off);
    sum     = seg_ext + off_ext;
  end
endmodule

// File: rtl/bit_gate.sv
module bit_gate #(
  parameter int W   = 24,
  parameter int BIT = 20
) (
  input  logic [W-1:0] din,
  input  logic         clear,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == BIT) begin : g_gated
      assign dout[i] = din[i] & ~clear;
    end else begin : g_pass
      assign dout[i] = din[i];
    end
  end
endmodule

// File: rtl/gate_reg.sv
module gate_reg #(
  parameter int CFG_W    = 8,
  parameter int OPEN_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic             open_q,
  output logic             open_next
);
  always_comb open_next = we ? wdata[OPEN_BIT] : open_q;

  always_ff @(posedge clk) begin
    if (rst) open_q <= 1'b0;
    else     open_q <= open_next;
  end

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(open_q)); // R8
  AST_GATE_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> (open_q == $past(wdata[OPEN_BIT]))); // R8
endmodule

// File: rtl/phys_addr_gen.sv
module phys_addr_gen
  import addr_gen_pkg::*;
#(
  parameter int P_SEG_W = SEG_W,
  parameter int P_OFF_W = OFF_W,
  parameter int P_SHIFT = SEG_SHIFT,
  parameter int P_PA_W  = PA_W,
  parameter int P_GATE  = GATE_BIT,
  parameter int P_CFG_W = CFG_W,
  localparam int HI_W   = P_SEG_W + P_SHIFT,
  localparam int SUM_W  = ((HI_W > P_OFF_W) ? HI_W : P_OFF_W) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [P_SEG_W-1:0] seg,
  input  logic [P_OFF_W-1:0] off,
  input  logic               prot_mode,
  input  logic [P_PA_W-1:0]  lin_addr,
  input  logic               mask_n,
  input  logic               cfg_we,
  input  logic [P_CFG_W-1:0] cfg_wdata,
  output logic               gate_open,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [P_PA_W-1:0]  phys_addr
);
  logic [SUM_W-1:0]  real_sum;
  logic [P_PA_W-1:0] real_ext;
  logic [P_PA_W-1:0] raw_addr;
  logic [P_PA_W-1:0] gated_addr;
  logic              open_next;
  logic              clear_bit;
  logic              accept;
  addr_mode_e        mode;

  seg_adder #(.SEG_W(P_SEG_W), .OFF_W(P_OFF_W), .SHIFT(P_SHIFT)) u_add (
    .seg(seg), .off(off), .sum(real_sum)
  );

  gate_reg #(.CFG_W(P_CFG_W), .OPEN_BIT(CFG_OPEN)) u_gate (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .open_q(gate_open), .open_next(open_next)
  );

  if (SUM_W < P_PA_W) begin : g_zext
    assign real_ext = {{(P_PA_W-SUM_W){1'b0}}, real_sum};
  end else begin : g_trunc
    assign real_ext = real_sum[P_PA_W-1:0];
  end

  always_comb begin
    mode      = addr_mode_e'(prot_mode);
    raw_addr  = (mode == MODE_PROT) ? lin_addr : real_ext;
    clear_bit = ~open_next | ~mask_n;
  end

  bit_gate #(.W(P_PA_W), .BIT(P_GATE)) u_mask (
    .din(raw_addr), .clear(clear_bit), .dout(gated_addr)
  );

  assign req_ready = ~out_valid | out_ready;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      phys_addr <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      phys_addr <= gated_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> out_valid); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(phys_addr))); // R10
  AST_PIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !mask_n) |=> !phys_addr[P_GATE]); // R6
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && prot_mode) |=>
      (phys_addr[P_PA_W-1:P_GATE+1] == $past(lin_addr[P_PA_W-1:P_GATE+1]))); // R4
  AST_LOWER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && prot_mode) |=>
      (phys_addr[P_GATE-1:0] == $past(lin_addr[P_GATE-1:0]))); // R7
endmodule

// File: tb/sim_phys_addr_gen.sv
`timescale 1ns/1ps
module sim_phys_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [15:0] seg, off;
  logic        prot_mode;
  logic [23:0] lin_addr;
  logic        mask_n, cfg_we;
  logic [7:0]  cfg_wdata;
  logic        gate_open, out_valid, out_ready;
  logic [23:0] phys_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  phys_addr_gen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .seg(seg), .off(off), .prot_mode(prot_mode), .lin_addr(lin_addr),
    .mask_n(mask_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .gate_open(gate_open), .out_valid(out_valid), .out_ready(out_ready),
    .phys_addr(phys_addr)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
        summary();
      end
    end
  end

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(logic [15:0] s, logic [15:0] o, logic p,
                                        logic [23:0] l, logic open, logic pin_n);
    logic [23:0] a;
    a = p ? l : ({8'h0, s} * 24'd16 + {8'h0, o});
    if (!open || !pin_n) a[20] = 1'b0;
    return a;
  endfunction

  task automatic write_gate(logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = 8'h00;
  endtask

  task automatic run_req(string req, logic [15:0] s, logic [15:0] o, logic p,
                         logic [23:0] l, logic pin_n, logic open);
    @(negedge clk);
    req_valid = 1'b1; seg = s; off = o; prot_mode = p; lin_addr = l; mask_n = pin_n;
    @(negedge clk);
    req_valid = 1'b0; mask_n = 1'b1;
    check({req, " valid"}, 24'(out_valid), 24'd1);
    check(req, phys_addr, model(s, o, p, l, open, pin_n));
  endtask

  logic [15:0] bs [4] = '{16'h0000_0000 >> 0, 16'hF000, 16'hF800, 16'hFFFF};
  logic [15:0] bo [4] = '{16'h0000, 16'hFFFF, 16'h8000, 16'hFFFF};

  initial begin
    rst = 1'b1; req_valid = 1'b0; seg = '0; off = '0; prot_mode = 1'b0;
    lin_addr = '0; mask_n = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5 gate closed", 24'(gate_open), 24'd0);
    check("R5 out_valid", 24'(out_valid), 24'd0);
    check("R5 req_ready", 24'(req_ready), 24'd1);

    // R2 named examples with gate closed after reset
    run_req("R2 F800:8000", 16'hF800, 16'h8000, 1'b0, '0, 1'b1, 1'b0);
    run_req("R2 FFFF:00D0", 16'hFFFF, 16'h00D0, 1'b0, '0, 1'b1, 1'b0);

    // R8 other data bits ignored: bit1=0 keeps closed, 0x02 opens
    write_gate(8'hFD);
    check("R8 bits other than 1 ignored", 24'(gate_open), 24'd0);
    write_gate(8'h02);
    check("R8 open", 24'(gate_open), 24'd1);
    run_req("R3 F800:8000", 16'hF800, 16'h8000, 1'b0, '0, 1'b1, 1'b1);
    run_req("R3 FFFF:FFFF", 16'hFFFF, 16'hFFFF, 1'b0, '0, 1'b1, 1'b1);

    // R1/R2/R3/R6 sweep: gate x pin x (boundary + random pairs)
    for (int g = 0; g < 2; g++) begin
      write_gate(g ? 8'h02 : 8'h00);
      check("R8 readback", 24'(gate_open), 24'(g));
      for (int pn = 0; pn < 2; pn++) begin
        for (int i = 0; i < 4; i++)
          run_req("R1 R6 boundary", bs[i], bo[i], 1'b0, '0, pn[0], g[0]);
        for (int i = 0; i < 200; i++)
          run_req("R1 R2 R3 random", 16'($urandom), 16'($urandom), 1'b0, '0, pn[0], g[0]);
      end
    end

    // R4/R7 protected mode, every megabyte, all gate/pin combinations
    for (int g = 0; g < 2; g++) begin
      write_gate(g ? 8'h02 : 8'h00);
      for (int pn = 0; pn < 2; pn++)
        for (int mb = 0; mb < 16; mb++)
          run_req("R4 R7 protected", 16'hFFFF, 16'hFFFF, 1'b1,
                  {mb[3:0], 20'h5A5A3}, pn[0], g[0]);
    end

    // R9 same-cycle write opens for that request
    write_gate(8'h00);
    @(negedge clk);
    req_valid = 1'b1; seg = 16'hF800; off = 16'h8000; prot_mode = 1'b0;
    cfg_we = 1'b1; cfg_wdata = 8'h02;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check("R9 open same cycle", phys_addr, 24'h100000);
    // R9 same-cycle write closes for that request
    @(negedge clk);
    req_valid = 1'b1; seg = 16'hFFFF; off = 16'h00D0; cfg_we = 1'b1; cfg_wdata = 8'h00;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check("R9 close same cycle", phys_addr, 24'h0000C0);

    // R10 back-pressure
    write_gate(8'h02);
    out_ready = 1'b0;
    run_req("R10 stalled result", 16'hF800, 16'h8000, 1'b0, '0, 1'b1, 1'b1);
    check("R10 req_ready low", 24'(req_ready), 24'd0);
    req_valid = 1'b1; seg = 16'h1234; off = 16'h0005;
    @(negedge clk);
    check("R10 held valid", 24'(out_valid), 24'd1);
    check("R10 held addr", phys_addr, 24'h100000);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 drain and accept", phys_addr, 24'h012345);
    @(negedge clk);
    check("R10 drained", 24'(out_valid), 24'd0);

    summary();
  end
endmodule